// File: doc/BRIEF.md
# Duplex Word Buffer with Transfer Status

This block sits between a 32-bit register bus and a serial shift engine and holds the words travelling in each direction. Software pushes transmit words into an outbound queue, and the engine drains them over a valid/ready word handshake. The engine pushes received words into an inbound queue, and software pops them from the bus. Both queues have the same depth, which is set at build time from a 2-bit block code and a 3-bit size code.

Each direction has a word counter with its own small state machine. Its states are CNT_IDLE, CNT_ACTIVE and CNT_DONE.
- Writing a non-zero limit moves the counter to CNT_ACTIVE. Writing zero moves it to CNT_IDLE.
- In CNT_ACTIVE, each counted word advances the counter. The counter goes to CNT_DONE on the word that makes the count equal to the limit, and it stays there until the next limit write.

Sticky status flags report the following:
- service: there is room to send, or there is data to fetch;
- done: a counter reached its limit.

Four error bits record queue misuse on either side. Status flags and error bits are cleared by writing ones. A single level interrupt stays high while any status flag is set, or while any error bit is set that its enable bit allows through.

Top module: `duplex_word_buffer`

## Requirements
- R1: After reset, both queues are empty, all flags, error bits and enable bits are zero, `irq` is low, `bus_rdata` is zero, `eng_tx_valid` is low and `eng_rx_ready` is high.
- R2: The queue depth is B*(2<<S) words. B is 4 when the block code is 0 and 16 times the code otherwise, and S is the size code. Words written to address 0 leave on the engine transmit port in write order. Words accepted from the engine are returned by reads of address 1 in arrival order. `eng_tx_data` holds steady while `eng_tx_valid` is high and `eng_tx_ready` is low.
- R3: A read of address 2 returns the live fill bits. Bit 4 is outbound queue not empty, bit 5 is inbound queue not empty, bit 6 is outbound queue full and bit 7 is inbound queue full.
- R4: A write to address 0 while the outbound queue is full drops the word and sets error bit 5 (outbound overrun).
- R5: A read of address 1 while the inbound queue is empty returns zero and sets error bit 4 (inbound underrun).
- R6: `eng_rx_ready` is low exactly when the inbound queue is full. A word offered with `eng_rx_valid` while the queue is full is dropped and sets error bit 2 (inbound overrun).
- R7: While the outbound counter is in CNT_ACTIVE, `eng_tx_ready` high with an empty outbound queue sets error bit 3 (outbound underrun). In CNT_IDLE or CNT_DONE this case sets no error.
- R8: Address 6 holds the outbound limit and address 7 holds the inbound limit. Writing a non-zero value to either restarts its count from zero in CNT_ACTIVE. Status bit 10 sets when the number of words taken by the engine reaches the outbound limit. Status bit 11 sets when the number of accepted inbound words reaches the inbound limit.
- R9: Status bit 8 (outbound service) sets on any cycle in which the outbound counter is in CNT_ACTIVE and the outbound queue is not full. Status bit 9 (inbound service) sets on any cycle in which the inbound queue holds data. Both stay set until cleared.
- R10: Writing to address 2 clears every status bit 8 to 11 whose write bit is one. Writing to address 3 clears every error bit whose write bit is one. A bit whose set condition holds in the same cycle stays set, and zero bits in the write leave bits untouched.
- R11: `irq` is high whenever any status bit 8 to 11 is set, or any error bit is set whose matching bit in the enable register at address 4 is one. The enable register uses the same bit positions as the error word.
- R12: Read data appears on `bus_rdata` in the cycle after the request and holds until the next read. Addresses 4, 6 and 7 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_tx_valid | output | 1 | Outbound word available |
| eng_tx_ready | input | 1 | Engine takes the outbound word |
| eng_tx_data | output | 32 | Head of the outbound queue |
| eng_rx_valid | input | 1 | Engine delivers an inbound word |
| eng_rx_ready | output | 1 | Inbound queue has room |
| eng_rx_data | input | 32 | Inbound word |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with both depth codes at zero, which gives eight-word queues. With this depth, every full-queue and empty-queue case is reached within a handful of bus accesses. Short limits of 2, 3 and 4 words let both counters reach CNT_DONE partway through a queue drain or fill. They also let a counter re-arm onto an empty queue and raise outbound underrun. A behavioural model built on queues predicts the engine ports, the interrupt and the read data on every cycle.

// File: rtl/dwb_pkg.sv
`timescale 1ns/1ps
package dwb_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_TXQ   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RXQ   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_ERR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ERREN = 3'd4;
    localparam logic [ADDR_W-1:0] A_TXLIM = 3'd6;
    localparam logic [ADDR_W-1:0] A_RXLIM = 3'd7;

    // field positions software decodes
    localparam int FILL_LO = 4;   // 4 fill bits: tx_ne, rx_ne, tx_full, rx_full
    localparam int FLAG_LO = 8;   // 4 flags: tx_svc, rx_svc, tx_done, rx_done
    localparam int ERR_LO  = 2;   // 4 errors: rx_ovr, tx_udr, rx_udr, tx_ovr

    typedef enum logic [1:0] {
        CNT_IDLE   = 2'd0,
        CNT_ACTIVE = 2'd1,
        CNT_DONE   = 2'd2
    } cnt_state_e;

    function automatic int fifo_depth(input int blk_code, input int size_code);
        int blk;
        blk = (blk_code == 0) ? 4 : 16 * blk_code;
        return blk * (2 << size_code);
    endfunction
endpackage

// File: rtl/dwb_fifo.sv
`timescale 1ns/1ps
module dwb_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/dwb_xfer_count.sv
`timescale 1ns/1ps
module dwb_xfer_count import dwb_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             armed,
    output logic             reached,
    output logic [CNT_W-1:0] limit
);
    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CNT_IDLE;
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        reached = 1'b0;
        unique case (st_q)
            CNT_IDLE: begin
            end
            CNT_ACTIVE: begin
                if (step) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_d == lim_q) begin
                        st_d    = CNT_DONE;
                        reached = 1'b1;
                    end
                end
            end
            CNT_DONE: begin
            end
            default: st_d = CNT_IDLE;
        endcase
        if (load) begin
            lim_d = load_val;
            cnt_d = '0;
            st_d  = (load_val == '0) ? CNT_IDLE : CNT_ACTIVE;
        end
    end

    assign armed = (st_q == CNT_ACTIVE);
    assign limit = lim_q;
endmodule

// File: rtl/duplex_word_buffer.sv
`timescale 1ns/1ps
module duplex_word_buffer import dwb_pkg::*; #(
    parameter int BLK_CODE  = 0,
    parameter int SIZE_CODE = 0,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_rx_valid,
    output logic              eng_rx_ready,
    input  logic [WORD_W-1:0] eng_rx_data
    ,output logic             irq
);
    localparam int DEPTH = fifo_depth(BLK_CODE, SIZE_CODE);

    logic wr_acc, rd_acc;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_head;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic tx_armed, rx_armed, tx_reached, rx_reached;
    logic [CNT_W-1:0] tx_lim, rx_lim;
    logic [3:0] err_q, err_set, err_clr;
    logic [3:0] en_q;
    logic [3:0] flag_q, flag_set, flag_clr;
    logic [WORD_W-1:0] stat_word, rd_mux, rdata_q;
    logic wdata_unused;

    assign wdata_unused = ^bus_wdata;
    assign wr_acc = bus_req && bus_wr;
    assign rd_acc = bus_req && !bus_wr;

    assign tx_push = wr_acc && (bus_addr == A_TXQ);
    assign tx_pop  = !tx_empty && eng_tx_ready;
    assign rx_push = eng_rx_valid;
    assign rx_pop  = rd_acc && (bus_addr == A_RXQ);

    dwb_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) tx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(bus_wdata), .pop(tx_pop),
        .head(eng_tx_data), .full(tx_full), .empty(tx_empty)
    );

    dwb_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) rx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(eng_rx_data), .pop(rx_pop),
        .head(rx_head), .full(rx_full), .empty(rx_empty)
    );

    dwb_xfer_count #(.CNT_W(CNT_W)) tx_cnt_i (
        .clk(clk), .rst_n(rst_n),
        .load(wr_acc && (bus_addr == A_TXLIM)), .load_val(bus_wdata[CNT_W-1:0]),
        .step(tx_pop), .armed(tx_armed), .reached(tx_reached), .limit(tx_lim)
    );

    dwb_xfer_count #(.CNT_W(CNT_W)) rx_cnt_i (
        .clk(clk), .rst_n(rst_n),
        .load(wr_acc && (bus_addr == A_RXLIM)), .load_val(bus_wdata[CNT_W-1:0]),
        .step(rx_push && !rx_full), .armed(rx_armed), .reached(rx_reached), .limit(rx_lim)
    );

    assign eng_tx_valid = !tx_empty;
    assign eng_rx_ready = !rx_full;

    // error events: [0] rx overrun, [1] tx underrun, [2] rx underrun, [3] tx overrun
    always_comb begin
        err_set[0] = eng_rx_valid && rx_full;
        err_set[1] = tx_armed && eng_tx_ready && tx_empty;
        err_set[2] = rx_pop && rx_empty;
        err_set[3] = tx_push && tx_full;
        flag_set[0] = tx_armed && !tx_full;
        flag_set[1] = !rx_empty;
        flag_set[2] = tx_reached;
        flag_set[3] = rx_reached;
        err_clr  = (wr_acc && (bus_addr == A_ERR))  ? bus_wdata[ERR_LO +: 4]  : 4'b0;
        flag_clr = (wr_acc && (bus_addr == A_STAT)) ? bus_wdata[FLAG_LO +: 4] : 4'b0;
    end

    always_comb begin
        stat_word = '0;
        stat_word[FILL_LO +: 4] = {rx_full, tx_full, !rx_empty, !tx_empty};
        stat_word[FLAG_LO +: 4] = flag_q;
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_RXQ:   rd_mux = rx_empty ? '0 : rx_head;
            A_STAT:  rd_mux = stat_word;
            A_ERR:   rd_mux[ERR_LO +: 4] = err_q;
            A_ERREN: rd_mux[ERR_LO +: 4] = en_q;
            A_TXLIM: rd_mux = WORD_W'(tx_lim);
            A_RXLIM: rd_mux = WORD_W'(rx_lim);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= '0;
            flag_q  <= '0;
            en_q    <= '0;
            rdata_q <= '0;
        end else begin
            err_q  <= (err_q & ~err_clr) | err_set;
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            if (wr_acc && (bus_addr == A_ERREN)) begin
                en_q <= bus_wdata[ERR_LO +: 4];
            end
            if (rd_acc) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign irq = (|(err_q & en_q)) || (|flag_q);
endmodule

// File: rtl/dwb_checker.sv
`timescale 1ns/1ps
module dwb_checker import dwb_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              eng_tx_valid,
    input logic              eng_tx_ready,
    input logic [WORD_W-1:0] eng_tx_data,
    input logic              eng_rx_valid,
    input logic              eng_rx_ready,
    input logic              irq,
    input logic [3:0]        err_q,
    input logic              tx_full,
    input logic              rx_empty
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid && !eng_tx_ready |=> eng_tx_valid && $stable(eng_tx_data)); // R2

    AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_wr && bus_addr == A_TXQ && tx_full |=> err_q[3]); // R4

    AST_RX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_wr && bus_addr == A_RXQ && rx_empty |=> err_q[2] && bus_rdata == '0); // R5

    AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_valid && !eng_rx_ready |=> err_q[0]); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_wr) |=> (err_q & $past(err_q)) == $past(err_q)); // R10

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(bus_req && bus_wr) |=> irq); // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_wr) |=> $stable(bus_rdata)); // R12
endmodule

bind duplex_word_buffer dwb_checker chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .irq(irq),
    .err_q(err_q), .tx_full(tx_full), .rx_empty(rx_empty)
);

// File: tb/duplex_word_buffer_tb_top.sv
`timescale 1ns/1ps
module duplex_word_buffer_tb_top;
    import dwb_pkg::*;
    localparam int D = fifo_depth(0, 0);
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic eng_tx_valid, eng_rx_ready, irq;
    logic eng_tx_ready = 1'b0, eng_rx_valid = 1'b0;
    logic [31:0] eng_tx_data;
    logic [31:0] eng_rx_data = '0;

    integer n_run = 0, n_fail = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    duplex_word_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
        .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
        .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] qo[$];
    logic [31:0] qi[$];
    logic [3:0]  m_err, m_en, m_flag, eset, fset, eclr, fclr;
    logic [31:0] m_rdata;
    int m_olim, m_ilim, m_ocnt, m_icnt, m_ost, m_ist;   // state: 0 idle, 1 active, 2 done
    bit ofull, oempty, ifull, iempty, wr, rd;

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        s = '0;
        s[4] = qo.size() != 0;
        s[5] = qi.size() != 0;
        s[6] = qo.size() == D;
        s[7] = qi.size() == D;
        s[11:8] = m_flag;
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            qo.delete(); qi.delete();
            m_err = '0; m_en = '0; m_flag = '0; m_rdata = '0;
            m_olim = 0; m_ilim = 0; m_ocnt = 0; m_icnt = 0; m_ost = 0; m_ist = 0;
        end else begin
            ofull = qo.size() == D; oempty = qo.size() == 0;
            ifull = qi.size() == D; iempty = qi.size() == 0;
            wr = bus_req && bus_wr; rd = bus_req && !bus_wr;
            eset = '0; fset = '0;
            if (rd) begin
                case (bus_addr)
                    A_RXQ:   m_rdata = iempty ? 32'h0 : qi[0];
                    A_STAT:  m_rdata = m_status();
                    A_ERR:   m_rdata = {26'b0, m_err, 2'b0};
                    A_ERREN: m_rdata = {26'b0, m_en, 2'b0};
                    A_TXLIM: m_rdata = m_olim;
                    A_RXLIM: m_rdata = m_ilim;
                    default: m_rdata = 32'h0;
                endcase
            end
            fset[0] = !ofull && m_ost == 1;
            fset[1] = !iempty;
            if (eng_tx_ready && oempty && m_ost == 1) eset[1] = 1'b1;
            if (!oempty && eng_tx_ready) begin
                void'(qo.pop_front());
                if (m_ost == 1) begin
                    m_ocnt++;
                    if (m_ocnt == m_olim) begin m_ost = 2; fset[2] = 1'b1; end
                end
            end
            if (wr && bus_addr == A_TXQ) begin
                if (ofull) eset[3] = 1'b1; else qo.push_back(bus_wdata);
            end
            if (rd && bus_addr == A_RXQ) begin
                if (iempty) eset[2] = 1'b1; else void'(qi.pop_front());
            end
            if (eng_rx_valid) begin
                if (ifull) eset[0] = 1'b1;
                else begin
                    qi.push_back(eng_rx_data);
                    if (m_ist == 1) begin
                        m_icnt++;
                        if (m_icnt == m_ilim) begin m_ist = 2; fset[3] = 1'b1; end
                    end
                end
            end
            if (wr && bus_addr == A_TXLIM) begin
                m_olim = int'(bus_wdata[15:0]); m_ocnt = 0; m_ost = (m_olim == 0) ? 0 : 1;
            end
            if (wr && bus_addr == A_RXLIM) begin
                m_ilim = int'(bus_wdata[15:0]); m_icnt = 0; m_ist = (m_ilim == 0) ? 0 : 1;
            end
            if (wr && bus_addr == A_ERREN) m_en = bus_wdata[5:2];
            eclr = (wr && bus_addr == A_ERR)  ? bus_wdata[5:2]  : 4'b0;
            fclr = (wr && bus_addr == A_STAT) ? bus_wdata[11:8] : 4'b0;
            m_err  = (m_err & ~eclr) | eset;
            m_flag = (m_flag & ~fclr) | fset;
        end
    end

    // every-cycle comparison, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                chk("R2", "tx_valid", {31'b0, eng_tx_valid}, {31'b0, qo.size() != 0});
                if (qo.size() != 0) chk("R2", "tx_data", eng_tx_data, qo[0]);
                chk("R6", "rx_ready", {31'b0, eng_rx_ready}, {31'b0, qi.size() < D});
                chk("R11", "irq", {31'b0, irq}, {31'b0, (|(m_err & m_en)) || (|m_flag)});
                chk("R12", "rdata", bus_rdata, m_rdata);
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * WD_CYCLES);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "irq", {31'b0, irq}, 32'h0);
        chk("R1", "tx_valid", {31'b0, eng_tx_valid}, 32'h0);
        chk("R1", "rx_ready", {31'b0, eng_rx_ready}, 32'h1);
        chk("R1", "rdata", bus_rdata, 32'h0);
        bus_read(A_STAT, rv); chk("R1", "status", rv, 32'h0);
        bus_read(A_ERR, rv);  chk("R1", "error", rv, 32'h0);

        // arm outbound, fill queue with engine stalled
        bus_write(A_TXLIM, 32'd3);
        for (int i = 0; i < D; i++) bus_write(A_TXQ, 32'h1000 + i);
        bus_read(A_STAT, rv); chk("R3", "status full tx (R9 svc)", rv, 32'h150);
        bus_write(A_TXQ, 32'hDEAD);
        bus_read(A_ERR, rv); chk("R4", "tx overrun", rv, 32'h20);
        bus_write(A_ERR, 32'h20);
        bus_read(A_ERR, rv); chk("R10", "error cleared", rv, 32'h0);

        // drain; counter reaches 3 midway
        @(negedge clk); eng_tx_ready = 1'b1;
        idle(12);
        eng_tx_ready = 1'b0;
        bus_read(A_STAT, rv); chk("R8", "tx done", rv, 32'h500);
        bus_write(A_STAT, 32'hF00);
        bus_read(A_STAT, rv); chk("R10", "status cleared", rv, 32'h0);
        bus_read(A_ERR, rv); chk("R7", "no underrun when done", rv, 32'h0);

        // re-arm onto empty queue with engine asking
        @(negedge clk); eng_tx_ready = 1'b1;
        bus_write(A_TXLIM, 32'd2);
        idle(2);
        bus_write(A_STAT, 32'hF00);
        bus_read(A_STAT, rv); chk("R10", "svc re-set while condition holds", rv, 32'h100);
        eng_tx_ready = 1'b0;
        bus_write(A_TXLIM, 32'd0);
        bus_read(A_ERR, rv); chk("R7", "tx underrun", rv, 32'h08);
        bus_write(A_ERR, 32'h3C);
        bus_write(A_STAT, 32'hF00);
        bus_read(A_STAT, rv); chk("R8", "disarmed, status clear", rv, 32'h0);
        chk("R11", "irq low", {31'b0, irq}, 32'h0);

        // inbound underrun
        bus_read(A_RXQ, rv); chk("R5", "empty read data", rv, 32'h0);
        bus_read(A_ERR, rv); chk("R5", "rx underrun", rv, 32'h10);
        bus_write(A_ERR, 32'h10);

        // inbound fill with overrun
        bus_write(A_RXLIM, 32'd4);
        for (int i = 0; i <= D; i++) begin
            @(negedge clk);
            eng_rx_valid = 1'b1; eng_rx_data = 32'hA0 + i;
        end
        @(negedge clk); eng_rx_valid = 1'b0;
        bus_read(A_STAT, rv); chk("R9", "rx full, svc, done (R3 R8)", rv, 32'hAA0);
        bus_read(A_ERR, rv);  chk("R6", "rx overrun", rv, 32'h04);
        bus_read(A_RXLIM, rv); chk("R12", "rx limit readback", rv, 32'd4);
        for (int i = 0; i < D; i++) begin
            bus_read(A_RXQ, rv); chk("R2", "rx order", rv, 32'hA0 + i);
        end
        bus_read(A_STAT, rv); chk("R9", "sticky after drain", rv, 32'hA00);
        bus_write(A_STAT, 32'hF00);
        bus_write(A_ERR, 32'h3C);
        bus_read(A_STAT, rv); chk("R10", "all clear", rv, 32'h0);

        // interrupt masking
        bus_read(A_RXQ, rv);
        @(negedge clk);
        chk("R11", "masked error", {31'b0, irq}, 32'h0);
        bus_write(A_ERREN, 32'h10);
        chk("R11", "enabled error", {31'b0, irq}, 32'h1);
        bus_read(A_ERREN, rv); chk("R12", "enable readback", rv, 32'h10);
        bus_write(A_ERR, 32'h10);
        chk("R11", "irq after clear", {31'b0, irq}, 32'h0);

        idle(3);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule